// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block turns word reads and writes on a memory-mapped bus window into serial flash transactions. For each accepted request it lowers chip select, shifts out an opcode and the address on one data line, MSB first, and runs any dummy clocks. It then runs the data phase and raises chip select again. Reads gather four bytes, either on one input line or on all four lines, and return them to the bus as one little-endian 32-bit word. Writes shift four bytes out on one line.

All of the frame shape comes from one 32-bit setup word:

| Setup bits | Meaning |
|---|---|
| [7:0] | Read opcode |
| [9:8] | Address byte count, minus one |
| [11:10] | Dummy byte count |
| [13:12] | Read line mode |
| [23:16] | Write opcode |
| [28:24] | Extra dummy clocks |

A one-bit switch decides who drives the flash pins. When the switch is set, this engine owns them. When it is clear, the register command port owns them. A change of the switch takes effect only when no transaction is running. The serial clock runs at half the system clock and idles low. Data goes out while the clock is low and is sampled while it is high.

Top module: `sfl_map_reader`

## Requirements
- R1: After reset the pins belong to the command port (`map_owner`=0), `req_ready` and `rsp_valid` are low, and the setup word is 0x0002_0203. That value means read opcode 0x03, three address bytes, no dummy clocks, single-line reads and write opcode 0x02.
- R2: While `map_owner` is 0, the pins follow the command port: `fl_cs_n`=`man_cs_n`, `fl_sclk`=`man_sclk`, `fl_io_out[0]`=`man_mosi`, and `fl_io_oe`=4'b0001.
- R3: A write of `mswitch_wbit` is applied to `map_owner` only while the engine is idle. A transaction that is already running keeps the pins until it completes. While `map_owner` is 0, `req_ready` stays low and requests are not accepted.
- R4: A transaction starts with the opcode on `fl_io_out[0]`, MSB first, over 8 clocks. The address follows over setup[9:8]+1 bytes. Those bytes are the low bytes of the word address (request address with bits 1:0 forced to zero), sent MSB first.
- R5: A read inserts 8*setup[11:10] + setup[28:24] dummy clocks after the address. When that count is zero, no dummy clocks are inserted.
- R6: A read in line mode 0, 1 or 2 takes 32 clocks and samples `fl_io_in[1]` once per clock. Bytes are placed little-endian: the first byte received goes to `rsp_rdata[7:0]`, with each byte's MSB arriving first.
- R7: Line mode 3 reads in 8 clocks. Each clock takes one nibble from `fl_io_in[3:0]`, the high nibble of each byte first. `fl_io_oe` is 0 for the whole quad data phase.
- R8: A bus write sends the write opcode setup[23:16] and the address, with no dummy clocks. It then sends `req_wdata` over 32 clocks, bits [7:0] first and MSB first within each byte. The response data is 0.
- R9: Chip select stays low from the cycle after acceptance until the last clock falls. `fl_sclk` is low whenever chip select is high. `rsp_valid` pulses for exactly one cycle, in the cycle chip select returns high.
- R10: The setup word is captured when a request is accepted. A setup write during a transaction does not change that transaction; the next one uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_we | input | 1 | Setup word write strobe |
| setup_wdata | input | 32 | Setup word write value |
| mswitch_we | input | 1 | Pin switch write strobe |
| mswitch_wbit | input | 1 | Pin switch value, 1 = engine owns pins |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted this cycle when valid |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Assembled read word |
| man_sclk | input | 1 | Command port serial clock |
| man_cs_n | input | 1 | Command port chip select |
| man_mosi | input | 1 | Command port data out |
| fl_sclk | output | 1 | Flash serial clock |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_out | output | 4 | Flash data lines out |
| fl_io_oe | output | 4 | Flash data line output enables |
| fl_io_in | input | 4 | Flash data lines in |
| map_owner | output | 1 | Pins currently owned by the engine |

## Verification
The bench includes a behavioural flash model that logs every bit clocked in and drives read data one clock ahead of sampling. It checks header contents, clock counts and assembled words for:
- three-byte and four-byte addressing,
- zero, one-byte and byte-plus-bit dummy counts,
- single-line and quad data phases.

A sequencer that skipped a zero-length dummy phase wrongly, or miscounted the dummy bits, would show the wrong total clock count and shifted data. A nibble or byte order mistake changes the returned word. Dropping the pin switch in the middle of a frame is provoked directly: a design that handed over the pins early would raise chip select before the response. A setup write during a frame exposes a design that reads the live setup word instead of the captured copy, because the logged opcode would be wrong.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  localparam int CNT_W = 7;
  localparam int TX_W  = 72;

  typedef struct packed {
    logic [2:0] rsv_hi;
    logic [4:0] dbits;
    logic [7:0] wr_op;
    logic [1:0] rsv_lo;
    logic [1:0] lines;
    logic [1:0] dbytes;
    logic [1:0] abytes;
    logic [7:0] rd_op;
  } setup_t;

  localparam logic [31:0] SETUP_RST = 32'h0002_0203;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_DONE
  } phase_t;

  function automatic logic is_quad(setup_t s);
    return s.lines == 2'd3;
  endfunction

  function automatic logic [CNT_W-1:0] addr_clks(setup_t s);
    return CNT_W'((int'(s.abytes) + 1) * 8);
  endfunction

  function automatic logic [CNT_W-1:0] dummy_clks(setup_t s);
    return CNT_W'(int'(s.dbytes) * 8 + int'(s.dbits));
  endfunction

  function automatic logic [CNT_W-1:0] data_clks(logic wr, logic quad);
    return (!wr && quad) ? CNT_W'(8) : CNT_W'(32);
  endfunction

  function automatic logic [31:0] swap_bytes(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Place one received sample into the word: bytes little-endian, bits MSB first.
  function automatic logic [31:0] rx_place(logic [31:0] w, logic [CNT_W-1:0] k,
                                           logic quad, logic [3:0] io);
    logic [31:0] r;
    int b;
    r = w;
    if (quad) begin
      b = int'(k[2:1]);
      r[b*8 + (k[0] ? 0 : 4) +: 4] = io;
    end else begin
      b = int'(k[4:3]);
      r[b*8 + 7 - int'(k[2:0])] = io[1];
    end
    return r;
  endfunction

endpackage

// File: rtl/sfl_cfg_regs.sv
module sfl_cfg_regs
  import sfl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        setup_we,
  input  logic [31:0] setup_wdata,
  input  logic        mswitch_we,
  input  logic        mswitch_wbit,
  input  logic        seq_idle,
  input  logic        accept,
  output setup_t      setup_q,
  output logic        owner
);

  logic sw_q;
  logic hand_over;

  assign hand_over = seq_idle && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= setup_t'(SETUP_RST);
      sw_q    <= 1'b0;
      owner   <= 1'b0;
    end else begin
      if (setup_we)   setup_q <= setup_t'(setup_wdata);
      if (mswitch_we) sw_q    <= mswitch_wbit;
      if (hand_over)  owner   <= sw_q;
    end
  end

endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
  import sfl_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              owner,
  input  setup_t            setup_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              accept,
  output logic              eng_sclk,
  output logic              eng_cs_n,
  output logic              eng_mosi,
  output logic [3:0]        eng_oe,
  output logic              smp_en,
  output logic [CNT_W-1:0]  smp_idx,
  output logic              smp_quad,
  output logic              rx_quad,
  output logic              busy,
  output logic              idle,
  output logic              done
);

  phase_t           ph;
  setup_t           cfg_l;
  logic             wr_l;
  logic             sclk_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] idx;
  logic [TX_W-1:0]  tx_sh;
  logic [TX_W-1:0]  tx_init;
  phase_t           ph_nx;

  function automatic phase_t next_of(phase_t p, setup_t s, logic wr);
    case (p)
      PH_CMD:   return PH_ADDR;
      PH_ADDR:  return (!wr && dummy_clks(s) != '0) ? PH_DUMMY : PH_DATA;
      PH_DUMMY: return PH_DATA;
      PH_DATA:  return PH_DONE;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] len_of(phase_t p, setup_t s, logic wr);
    case (p)
      PH_CMD:   return CNT_W'(8);
      PH_ADDR:  return addr_clks(s);
      PH_DUMMY: return dummy_clks(s);
      PH_DATA:  return data_clks(wr, is_quad(s));
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    logic [31:0] a32;
    int          sh;
    a32 = 32'(req_addr) & 32'hFFFF_FFFC;
    sh  = 8 * (3 - int'(setup_in.abytes));
    tx_init = {(req_write ? setup_in.wr_op : setup_in.rd_op), a32 << sh, 32'h0};
    if (req_write)
      tx_init = tx_init | ({40'h0, swap_bytes(req_wdata)} << sh);
  end

  assign idle      = (ph == PH_IDLE);
  assign done      = (ph == PH_DONE);
  assign busy      = !idle && !done;
  assign req_ready = idle && owner;
  assign accept    = req_valid && req_ready;
  assign ph_nx     = next_of(ph, cfg_l, wr_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cfg_l  <= setup_t'(SETUP_RST);
      wr_l   <= 1'b0;
      sclk_q <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      tx_sh  <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (accept) begin
            cfg_l  <= setup_in;
            wr_l   <= req_write;
            tx_sh  <= tx_init;
            ph     <= PH_CMD;
            cnt    <= CNT_W'(8);
            idx    <= '0;
            sclk_q <= 1'b0;
          end
        end
        PH_DONE: ph <= PH_IDLE;
        default: begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            tx_sh  <= tx_sh << 1;
            if (ph == PH_DATA) idx <= idx + 1'b1;
            if (cnt == CNT_W'(1)) begin
              ph  <= ph_nx;
              cnt <= len_of(ph_nx, cfg_l, wr_l);
              idx <= '0;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign rx_quad  = (ph == PH_DATA) && !wr_l && is_quad(cfg_l);
  assign smp_en   = (ph == PH_DATA) && !wr_l && sclk_q;
  assign smp_idx  = idx;
  assign smp_quad = is_quad(cfg_l);
  assign eng_sclk = sclk_q;
  assign eng_cs_n = !busy;
  assign eng_mosi = busy ? tx_sh[TX_W-1] : 1'b0;
  assign eng_oe   = rx_quad ? 4'b0000 : 4'b0001;

endmodule

// File: rtl/sfl_rx_asm.sv
module sfl_rx_asm
  import sfl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             smp_en,
  input  logic [CNT_W-1:0] smp_idx,
  input  logic             smp_quad,
  input  logic [3:0]       io_in,
  output logic [31:0]      word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (clear)  word <= '0;
    else if (smp_en) word <= rx_place(word, smp_idx, smp_quad, io_in);
  end

endmodule

// File: rtl/sfl_pin_mux.sv
module sfl_pin_mux (
  input  logic       owner,
  input  logic       eng_sclk,
  input  logic       eng_cs_n,
  input  logic       eng_mosi,
  input  logic [3:0] eng_oe,
  input  logic       man_sclk,
  input  logic       man_cs_n,
  input  logic       man_mosi,
  output logic       fl_sclk,
  output logic       fl_cs_n,
  output logic [3:0] fl_io_out,
  output logic [3:0] fl_io_oe
);

  always_comb begin
    if (owner) begin
      fl_sclk   = eng_sclk;
      fl_cs_n   = eng_cs_n;
      fl_io_out = {3'b000, eng_mosi};
      fl_io_oe  = eng_oe;
    end else begin
      fl_sclk   = man_sclk;
      fl_cs_n   = man_cs_n;
      fl_io_out = {3'b000, man_mosi};
      fl_io_oe  = 4'b0001;
    end
  end

endmodule

// File: rtl/sfl_map_reader.sv
module sfl_map_reader
  import sfl_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_we,
  input  logic [31:0]       setup_wdata,
  input  logic              mswitch_we,
  input  logic              mswitch_wbit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              man_sclk,
  input  logic              man_cs_n,
  input  logic              man_mosi,
  output logic              fl_sclk,
  output logic              fl_cs_n,
  output logic [3:0]        fl_io_out,
  output logic [3:0]        fl_io_oe,
  input  logic [3:0]        fl_io_in,
  output logic              map_owner
);

  setup_t           setup_q;
  logic             accept;
  logic             seq_idle;
  logic             seq_busy;
  logic             seq_done;
  logic             smp_en;
  logic [CNT_W-1:0] smp_idx;
  logic             smp_quad;
  logic             rx_quad;
  logic             eng_sclk;
  logic             eng_cs_n;
  logic             eng_mosi;
  logic [3:0]       eng_oe;

  sfl_cfg_regs u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .setup_we     (setup_we),
    .setup_wdata  (setup_wdata),
    .mswitch_we   (mswitch_we),
    .mswitch_wbit (mswitch_wbit),
    .seq_idle     (seq_idle),
    .accept       (accept),
    .setup_q      (setup_q),
    .owner        (map_owner)
  );

  sfl_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .owner     (map_owner),
    .setup_in  (setup_q),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .accept    (accept),
    .eng_sclk  (eng_sclk),
    .eng_cs_n  (eng_cs_n),
    .eng_mosi  (eng_mosi),
    .eng_oe    (eng_oe),
    .smp_en    (smp_en),
    .smp_idx   (smp_idx),
    .smp_quad  (smp_quad),
    .rx_quad   (rx_quad),
    .busy      (seq_busy),
    .idle      (seq_idle),
    .done      (seq_done)
  );

  sfl_rx_asm u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .smp_en   (smp_en),
    .smp_idx  (smp_idx),
    .smp_quad (smp_quad),
    .io_in    (fl_io_in),
    .word     (rsp_rdata)
  );

  sfl_pin_mux u_mux (
    .owner     (map_owner),
    .eng_sclk  (eng_sclk),
    .eng_cs_n  (eng_cs_n),
    .eng_mosi  (eng_mosi),
    .eng_oe    (eng_oe),
    .man_sclk  (man_sclk),
    .man_cs_n  (man_cs_n),
    .man_mosi  (man_mosi),
    .fl_sclk   (fl_sclk),
    .fl_cs_n   (fl_cs_n),
    .fl_io_out (fl_io_out),
    .fl_io_oe  (fl_io_oe)
  );

  assign rsp_valid = seq_done;

endmodule

// File: rtl/sfl_map_reader_chk.sv
module sfl_map_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       seq_busy,
  input logic       smp_en,
  input logic       rx_quad,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       map_owner,
  input logic       man_cs_n,
  input logic       fl_cs_n,
  input logic       fl_sclk,
  input logic [3:0] fl_io_oe
);

  a_r9_cs_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !fl_cs_n);

  a_r9_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_rsp_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(seq_busy) && fl_cs_n));

  a_r9_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (map_owner && fl_cs_n) |-> !fl_sclk);

  a_r3_owner_held: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(map_owner));

  a_r3_stall_manual: assert property (@(posedge clk) disable iff (!rst_n)
    !map_owner |-> !req_ready);

  a_r2_manual_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_owner && !seq_busy) |-> (fl_cs_n == man_cs_n));

  a_r7_quad_release: assert property (@(posedge clk) disable iff (!rst_n)
    rx_quad |-> (fl_io_oe == 4'b0000));

  a_r6_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |-> fl_sclk);

endmodule

bind sfl_map_reader sfl_map_reader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seq_busy  (seq_busy),
  .smp_en    (smp_en),
  .rx_quad   (rx_quad),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .map_owner (map_owner),
  .man_cs_n  (man_cs_n),
  .fl_cs_n   (fl_cs_n),
  .fl_sclk   (fl_sclk),
  .fl_io_oe  (fl_io_oe)
);

// File: tb/sfl_map_reader_bench.sv
`timescale 1ns/1ps
module sfl_map_reader_bench;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          setup_we = 1'b0;
  logic [31:0]   setup_wdata = '0;
  logic          mswitch_we = 1'b0;
  logic          mswitch_wbit = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          man_sclk = 1'b0;
  logic          man_cs_n = 1'b1;
  logic          man_mosi = 1'b0;
  logic          fl_sclk;
  logic          fl_cs_n;
  logic [3:0]    fl_io_out;
  logic [3:0]    fl_io_oe;
  logic [3:0]    fl_io_in;
  logic          map_owner;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sfl_map_reader #(.ADDR_W(AW)) u_sfl_map_reader (
    .clk(clk), .rst_n(rst_n), .setup_we(setup_we), .setup_wdata(setup_wdata),
    .mswitch_we(mswitch_we), .mswitch_wbit(mswitch_wbit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .man_sclk(man_sclk), .man_cs_n(man_cs_n), .man_mosi(man_mosi),
    .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n), .fl_io_out(fl_io_out),
    .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in), .map_owner(map_owner)
  );

  // ---------------- flash model ----------------
  int         b_nb = 3;
  int         b_hdr = 0;
  bit         b_quad = 1'b0;
  int         count = 0;
  int         last_count = 0;
  bit [0:127] mosi_log = '0;
  logic [3:0] fio = 4'h0;

  assign fl_io_in = fio;

  function automatic logic [7:0] mb(logic [31:0] a);
    return (a[7:0] * 8'd7) ^ 8'hA5 ^ a[15:8];
  endfunction

  function automatic logic [31:0] log_bits(int start, int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[30:0], mosi_log[start + i]};
    return v;
  endfunction

  always @(posedge fl_sclk or negedge fl_sclk or posedge fl_cs_n) begin
    if (fl_cs_n) begin
      last_count = count;
      count = 0;
    end else if (fl_sclk) begin
      if (count < 128) mosi_log[count] = fl_io_out[0];
      count++;
    end else if (b_hdr > 0 && count >= b_hdr && count - b_hdr < 32) begin
      int k;
      logic [31:0] fa;
      logic [7:0] v;
      k  = count - b_hdr;
      fa = log_bits(8, b_nb * 8);
      if (b_quad) begin
        v   = mb(fa + 32'(k / 2));
        fio = (k % 2 == 0) ? v[7:4] : v[3:0];
      end else begin
        v   = mb(fa + 32'(k / 8));
        fio = {2'b00, v[7 - (k % 8)], 1'b0};
      end
    end
  end

  // ---------------- check helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_setup(input logic [31:0] v);
    @(negedge clk); setup_we = 1'b1; setup_wdata = v;
    @(negedge clk); setup_we = 1'b0;
  endtask

  task automatic wr_switch(input logic v);
    @(negedge clk); mswitch_we = 1'b1; mswitch_wbit = v;
    @(negedge clk); mswitch_we = 1'b0;
  endtask

  task automatic model_cfg(input logic [31:0] s, input bit wr);
    int dum;
    b_nb   = int'(s[9:8]) + 1;
    dum    = int'(s[11:10]) * 8 + int'(s[28:24]);
    b_quad = (s[13:12] == 2'd3);
    b_hdr  = wr ? 0 : 8 + 8 * b_nb + dum;
  endtask

  task automatic send_req(input bit wr, input logic [31:0] addr, input logic [31:0] wd);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr[AW-1:0]; req_wdata = wd;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [31:0] rd, output int oe0, output int cs_hi);
    int n = 0;
    oe0 = 0; cs_hi = 0;
    while (!rsp_valid && n < 3000) begin
      if (fl_io_oe == 4'b0000) oe0++;
      if (fl_cs_n) cs_hi++;
      @(negedge clk); n++;
    end
    chk("R9 response arrives", 32'(rsp_valid), 32'd1);
    chk("R9 cs high with response", 32'(fl_cs_n), 32'd1);
    rd = rsp_rdata;
    @(negedge clk);
    chk("R9 response single cycle", 32'(rsp_valid), 32'd0);
  endtask

  function automatic logic [31:0] addr_sent(logic [31:0] a, int nb);
    logic [31:0] m;
    m = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 1);
    return (a & 32'hFFFF_FFFC) & m;
  endfunction

  function automatic logic [31:0] exp_word(logic [31:0] a);
    logic [31:0] b;
    b = a & 32'hFFFF_FFFC & 32'h00FF_FFFF;
    return {mb(b + 3), mb(b + 2), mb(b + 1), mb(b)};
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 owner after reset", 32'(map_owner), 32'd0);
    chk("R1 ready low after reset", 32'(req_ready), 32'd0);
    chk("R1 rsp low after reset", 32'(rsp_valid), 32'd0);
    chk("R1 cs follows idle manual port", 32'(fl_cs_n), 32'd1);
  endtask

  task automatic t_manual();
    @(negedge clk); man_cs_n = 1'b0; man_sclk = 1'b1; man_mosi = 1'b1;
    #0.5;
    chk("R2 manual cs", 32'(fl_cs_n), 32'd0);
    chk("R2 manual sclk", 32'(fl_sclk), 32'd1);
    chk("R2 manual mosi", 32'(fl_io_out[0]), 32'd1);
    chk("R2 manual oe", 32'(fl_io_oe), 32'h1);
    @(negedge clk); man_sclk = 1'b0; man_mosi = 1'b0;
    @(negedge clk); man_cs_n = 1'b1;
  endtask

  task automatic t_read(input string req, input logic [31:0] s, input logic [31:0] addr);
    logic [31:0] rd;
    int oe0, cs_hi;
    wr_setup(s);
    model_cfg(s, 1'b0);
    send_req(1'b0, addr, 32'h0);
    wait_rsp(rd, oe0, cs_hi);
    chk({req, " R4 opcode"}, log_bits(0, 8), 32'(s[7:0]));
    chk({req, " R4 address"}, log_bits(8, b_nb * 8), addr_sent(addr, b_nb));
    chk({req, " R5 total clocks"}, 32'(last_count), 32'(b_hdr + (b_quad ? 8 : 32)));
    chk({req, " R6 data word"}, rd, exp_word(addr));
    chk({req, " R9 cs held"}, 32'(cs_hi), 32'd0);
    chk({req, " R7 line release"}, 32'(oe0 > 0), 32'(b_quad));
  endtask

  task automatic t_write();
    logic [31:0] rd;
    int oe0, cs_hi;
    logic [31:0] s = 32'h0002_366B;
    wr_setup(s);
    model_cfg(s, 1'b1);
    b_nb = 3;
    send_req(1'b1, 32'h00_4566, 32'hA1B2_C3D4);
    wait_rsp(rd, oe0, cs_hi);
    chk("R8 write opcode", log_bits(0, 8), 32'h02);
    chk("R8 write address", log_bits(8, 24), 32'h00_4564);
    chk("R8 write data byte0 first", log_bits(32, 32), 32'hD4C3_B2A1);
    chk("R8 write clocks no dummy", 32'(last_count), 32'd64);
    chk("R8 write response zero", rd, 32'h0);
    chk("R8 write keeps io0 driven", 32'(oe0), 32'd0);
  endtask

  task automatic t_setup_capture();
    logic [31:0] rd;
    int oe0, cs_hi;
    wr_setup(32'h0002_0203);
    model_cfg(32'h0002_0203, 1'b0);
    send_req(1'b0, 32'h00_0100, 32'h0);
    repeat (3) @(negedge clk);
    wr_setup(32'h0002_060B);
    wait_rsp(rd, oe0, cs_hi);
    chk("R10 old opcode kept", log_bits(0, 8), 32'h03);
    chk("R10 old clock count kept", 32'(last_count), 32'd64);
    chk("R10 old frame data", rd, exp_word(32'h100));
    model_cfg(32'h0002_060B, 1'b0);
    send_req(1'b0, 32'h00_0200, 32'h0);
    wait_rsp(rd, oe0, cs_hi);
    chk("R10 new opcode used", log_bits(0, 8), 32'h0B);
    chk("R10 new data", rd, exp_word(32'h200));
  endtask

  task automatic t_switch_off();
    logic [31:0] rd;
    int oe0, cs_hi, rdy;
    wr_setup(32'h0002_0203);
    model_cfg(32'h0002_0203, 1'b0);
    send_req(1'b0, 32'h00_0A0C, 32'h0);
    wr_switch(1'b0);
    chk("R3 owner kept mid frame", 32'(map_owner), 32'd1);
    chk("R3 cs kept mid frame", 32'(fl_cs_n), 32'd0);
    wait_rsp(rd, oe0, cs_hi);
    chk("R3 frame completes", rd, exp_word(32'h0A0C));
    chk("R3 cs not dropped early", 32'(cs_hi), 32'd0);
    repeat (3) @(negedge clk);
    chk("R3 owner released after frame", 32'(map_owner), 32'd0);
    rdy = 0;
    req_valid = 1'b1; req_write = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (req_ready) rdy++; end
    req_valid = 1'b0;
    chk("R3 stall while manual", 32'(rdy), 32'd0);
    chk("R3 no response while manual", 32'(rsp_valid), 32'd0);
    man_cs_n = 1'b0;
    #0.5;
    chk("R2 pins back to manual port", 32'(fl_cs_n), 32'd0);
    @(negedge clk); man_cs_n = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4ns * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_manual();
    wr_switch(1'b1);
    repeat (2) @(negedge clk);
    chk("R2 switch hands pins to engine", 32'(map_owner), 32'd1);
    chk("R9 sclk idles low", 32'(fl_sclk), 32'd0);
    t_read("R6 normal read", 32'h0002_0203, 32'h00_1236);
    t_read("R5 fast read one dummy byte", 32'h0002_060B, 32'h00_8AC0);
    t_read("R7 quad read", 32'h0002_366B, 32'h00_55A4);
    t_read("R5 four byte addr dummy bits mode1", 32'h0500_130B, 32'h00_C3F8);
    t_read("R7 quad with dummy bits", 32'h0302_366B, 32'h00_0010);
    t_write();
    t_setup_capture();
    t_switch_off();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule